// File: doc/BRIEF.md
# Processor Control Register and Parity Error Latch

This block sits on the I/O side of a processor and gives it two things: a write-only control register whose bits steer local memory, parity checking, the bus lock and a set of indicator lamps, and a sticky latch that records a parity error seen on a checked access to the lowest local page. A recorded error raises an interrupt until software clears it.

The I/O space is only partly decoded. Each of four address bits selects one function on its own, so a single access can reach several functions at once. Bit 11 selects an external interrupt controller, bit 12 an external debug port, bit 13 the control register and bit 14 the parity-latch clear. The block produces only the selects for the two external functions. Their logic lives elsewhere.

The register's bits for local-memory disable and parity-check enable are active low. A register of zero, the state after reset, therefore leaves local memory off and parity checking on. Every write to the register also copies the current latch state to a parity indicator.

Top module: `proc_ctrl_latch`

## Requirements
- R1: `pic_sel` is high exactly when `io_req` is high and `io_addr[11]` is 1, and `dbg_sel` is high exactly when `io_req` is high and `io_addr[12]` is 1. The check is combinational and ignores `io_we`. The two selects can be high together.
- R2: The control register loads `io_wdata[6:0]` at the clock edge where `io_req`, `io_we` and `io_addr[13]` are all 1. The new value is visible from that edge on. Any other access, including a read with `io_addr[13]` set, leaves the register unchanged.
- R3: The register outputs are `local_mem_on` = bit 0, `parity_chk_on` = NOT bit 1, `bus_lock` = bit 2, `rom_led` = bit 3 and `ind_led[2:0]` = bits 6..4. Bit 7 of the write data has no effect.
- R4: After synchronous reset (`rst_n` low at a clock edge), the register is zero. So `local_mem_on`=0 and `parity_chk_on`=1, and `bus_lock`, `rom_led`, `ind_led`, `err_led` and `parity_irq` are all 0.
- R5: The latch sets at a clock edge where `mem_valid`, `mem_perr` and `parity_chk_on` are all 1 and the access is in the low page. If any one of these is missing, the latch does not set.
- R6: An access is in the low page when `mem_addr[19:12]` (address bits above the 4K page) are all zero.
- R7: Once set, the latch stays set until it is cleared. `parity_irq` is the latch state.
- R8: A write with `io_addr[14]`=1 clears the latch at that edge, whatever the data. A read with `io_addr[14]`=1 does not clear it.
- R9: If a clear and a set condition fall on the same edge, the latch ends up set.
- R10: At every control-register write, `err_led` takes the latch state from before that edge. Between writes it holds.
- R11: A single write with both `io_addr[13]` and `io_addr[14]` set loads the register and clears the latch together. `err_led` receives the state from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | I/O access valid this cycle |
| io_we | input | 1 | Access is a write |
| io_addr | input | 20 | I/O address; bits 11 to 14 each select a function |
| io_wdata | input | 8 | Write data; bits 6..0 feed the control register |
| mem_valid | input | 1 | A local-memory access completes this cycle |
| mem_addr | input | 20 | Address of that access |
| mem_perr | input | 1 | Parity error reported for that access |
| pic_sel | output | 1 | Interrupt-controller select |
| dbg_sel | output | 1 | Debug-port select |
| local_mem_on | output | 1 | Low local page enabled (register bit 0) |
| parity_chk_on | output | 1 | Parity checking enabled (register bit 1 inverted) |
| bus_lock | output | 1 | Bus-lock request, holds the other processor waiting |
| rom_led | output | 1 | ROM-select indicator |
| ind_led | output | 3 | General indicators |
| err_led | output | 1 | Parity indicator captured at register writes |
| parity_irq | output | 1 | Parity interrupt, high while the latch is set |

## Verification
A wrong register bit shows up on its field output one edge after the write that should have set it. Because the outputs are the register itself, nothing hides the fault. A wrong latch state shows on `parity_irq` one edge after the offending set or clear. It also shows on `err_led` after the next register write, which catches a mix-up between pre-edge and post-edge latch values. The sweeps cover every register value and every combination of the four latch conditions. They also place clears, sets and register writes together on one edge, where priority mistakes become visible.

// File: rtl/pcl_pkg.sv
// Package: shared constants and types for the processor control register block.
// Assumes the I/O address is at least 15 bits wide so bits 11..14 exist.
package pcl_pkg;

    // Address bit that selects each function of the partially decoded I/O space
    localparam int SEL_PIC_BIT  = 11;
    localparam int SEL_DBG_BIT  = 12;
    localparam int SEL_CTRL_BIT = 13;
    localparam int SEL_CLR_BIT  = 14;

    // Number of control-register bits that carry a function
    localparam int CTRL_W = 7;

    // Control register layout, most significant field first
    typedef struct packed {
        logic [2:0] ind;      // bits 6..4 : indicator lamps
        logic       rom_sel;  // bit 3     : ROM-select indicator
        logic       lock;     // bit 2     : bus-lock request
        logic       chk_n;    // bit 1     : parity check enable, active low
        logic       lmem;     // bit 0     : local memory disable, active low
    } ctrl_t;

endpackage

// File: rtl/pcl_io_decode.sv
// Module: partial address decode of the I/O space.
// Each function is selected by a single address bit, so several selects can
// be active in one access. External selects follow any access; register load
// and latch clear need a write.
module pcl_io_decode
    import pcl_pkg::*;
#(
    parameter int IO_AW = 20
) (
    input  logic             io_req,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    output logic             pic_sel,
    output logic             dbg_sel,
    output logic             ctrl_wr,
    output logic             par_clr
);

    logic wr_acc;
    logic addr_unused;

    // Purpose: form a qualified write strobe
    always_comb wr_acc = io_req & io_we;

    // Purpose: one select per address bit, no mutual exclusion
    always_comb begin
        pic_sel = io_req & io_addr[SEL_PIC_BIT];
        dbg_sel = io_req & io_addr[SEL_DBG_BIT];
        ctrl_wr = wr_acc & io_addr[SEL_CTRL_BIT];
        par_clr = wr_acc & io_addr[SEL_CLR_BIT];
    end

    // Purpose: the remaining address bits take no part in the decode
    assign addr_unused = ^{io_addr[SEL_PIC_BIT-1:0], io_addr[IO_AW-1:SEL_CLR_BIT+1]};

endmodule

// File: rtl/pcl_ctrl_reg.sv
// Module: write-only control register and parity indicator capture.
// Loads on a qualified write; at the same edge captures the latch state
// as it stood before that edge. Clears to zero on reset.
module pcl_ctrl_reg
    import pcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              par_state,
    output ctrl_t             ctrl_q,
    output logic              err_led
);

    // Purpose: hold the register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end

    // Purpose: copy the pre-edge latch state to the indicator on each write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_led <= 1'b0;
        end else if (ctrl_wr) begin
            err_led <= par_state;
        end
    end

endmodule

// File: rtl/pcl_parity_latch.sv
// Module: sticky parity-error latch.
// Sets on a reported error for a checked access in the low page. Clears on a
// dedicated write. When both happen at one edge, the set wins.
module pcl_parity_latch #(
    parameter int MEM_AW  = 20,
    parameter int PAGE_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              mem_valid,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_perr,
    input  logic              clr,
    output logic              pending
);

    logic low_page;
    logic set_req;
    logic page_unused;

    // Purpose: detect the low page, or treat all of memory as one page
    generate
        if (PAGE_AW >= MEM_AW) begin : g_one_page
            assign low_page    = 1'b1;
            assign page_unused = ^mem_addr;
        end else begin : g_paged
            assign low_page    = ~|mem_addr[MEM_AW-1:PAGE_AW];
            assign page_unused = ^mem_addr[PAGE_AW-1:0];
        end
    endgenerate

    // Purpose: combined set condition
    always_comb set_req = mem_valid & mem_perr & chk_en & low_page;

    // Purpose: sticky state, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (set_req) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/proc_ctrl_latch.sv
// Module: top of the processor control register and parity latch block.
// Ties the I/O decode, the control register and the parity latch together
// and maps the register fields to their outputs. Active-low fields are turned
// into active-high enables here.
module proc_ctrl_latch
    import pcl_pkg::*;
#(
    parameter int IO_AW   = 20,
    parameter int MEM_AW  = 20,
    parameter int PAGE_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              mem_valid,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_perr,
    output logic              pic_sel,
    output logic              dbg_sel,
    output logic              local_mem_on,
    output logic              parity_chk_on,
    output logic              bus_lock,
    output logic              rom_led,
    output logic [2:0]        ind_led,
    output logic              err_led,
    output logic              parity_irq
);

    logic  ctrl_wr;
    logic  par_clr;
    logic  pending;
    ctrl_t ctrl_q;
    logic  wdata_unused;

    pcl_io_decode #(
        .IO_AW (IO_AW)
    ) i_decode (
        .io_req  (io_req),
        .io_we   (io_we),
        .io_addr (io_addr),
        .pic_sel (pic_sel),
        .dbg_sel (dbg_sel),
        .ctrl_wr (ctrl_wr),
        .par_clr (par_clr)
    );

    pcl_ctrl_reg i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wdata     (io_wdata[CTRL_W-1:0]),
        .par_state (pending),
        .ctrl_q    (ctrl_q),
        .err_led   (err_led)
    );

    pcl_parity_latch #(
        .MEM_AW  (MEM_AW),
        .PAGE_AW (PAGE_AW)
    ) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_en    (parity_chk_on),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_perr  (mem_perr),
        .clr       (par_clr),
        .pending   (pending)
    );

    // Purpose: map register fields to outputs, inverting the active-low ones
    always_comb begin
        local_mem_on  = ctrl_q.lmem;
        parity_chk_on = ~ctrl_q.chk_n;
        bus_lock      = ctrl_q.lock;
        rom_led       = ctrl_q.rom_sel;
        ind_led       = ctrl_q.ind;
        parity_irq    = pending;
    end

    // Purpose: the top write-data bit has no function
    assign wdata_unused = io_wdata[7];

endmodule

// File: rtl/proc_ctrl_latch_chk.sv
// Module: checker for proc_ctrl_latch, attached by bind.
// Relates port behaviour across clock edges; disabled while in reset.
module proc_ctrl_latch_chk
    import pcl_pkg::*;
#(
    parameter int IO_AW   = 20,
    parameter int MEM_AW  = 20,
    parameter int PAGE_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_req,
    input logic              io_we,
    input logic [IO_AW-1:0]  io_addr,
    input logic [7:0]        io_wdata,
    input logic              mem_valid,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_perr,
    input logic              pic_sel,
    input logic              dbg_sel,
    input logic              local_mem_on,
    input logic              parity_chk_on,
    input logic              bus_lock,
    input logic              rom_led,
    input logic [2:0]        ind_led,
    input logic              err_led,
    input logic              parity_irq
);

    logic          wr_ctrl;
    logic          wr_clr;
    logic          set_cond;
    logic [CTRL_W-1:0] fields;

    assign wr_ctrl  = io_req && io_we && io_addr[SEL_CTRL_BIT];
    assign wr_clr   = io_req && io_we && io_addr[SEL_CLR_BIT];
    assign set_cond = mem_valid && mem_perr && parity_chk_on &&
                      (mem_addr[MEM_AW-1:PAGE_AW] == '0);
    assign fields   = {ind_led, rom_led, bus_lock, ~parity_chk_on, local_mem_on};

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> fields == $past(io_wdata[CTRL_W-1:0])); // R2

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(fields)); // R2

    AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        set_cond |=> parity_irq); // R9

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!parity_irq && !set_cond) |=> !parity_irq); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_irq && !wr_clr) |=> parity_irq); // R7

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !set_cond) |=> !parity_irq); // R8

    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> err_led == $past(parity_irq)); // R10

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(err_led)); // R10

endmodule

bind proc_ctrl_latch proc_ctrl_latch_chk #(
    .IO_AW   (IO_AW),
    .MEM_AW  (MEM_AW),
    .PAGE_AW (PAGE_AW)
) i_chk (.*);

// File: tb/test_proc_ctrl_latch.sv
`timescale 1ns/1ps
module test_proc_ctrl_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [19:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        mem_valid = 1'b0;
    logic [19:0] mem_addr = '0;
    logic        mem_perr = 1'b0;
    logic        pic_sel, dbg_sel, local_mem_on, parity_chk_on, bus_lock;
    logic        rom_led, err_led, parity_irq;
    logic [2:0]  ind_led;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the state, built from the requirements
    logic [6:0] m_ctrl = '0;
    logic       m_latch = 1'b0;
    logic       m_err = 1'b0;

    always #2 clk = ~clk;

    proc_ctrl_latch i_proc_ctrl_latch (
        .clk, .rst_n, .io_req, .io_we, .io_addr, .io_wdata,
        .mem_valid, .mem_addr, .mem_perr,
        .pic_sel, .dbg_sel, .local_mem_on, .parity_chk_on, .bus_lock,
        .rom_led, .ind_led, .err_led, .parity_irq
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] act_vec();
        return {7'd0, local_mem_on, parity_chk_on, bus_lock, rom_led, ind_led, err_led, parity_irq};
    endfunction

    function automatic logic [15:0] exp_vec();
        return {7'd0, m_ctrl[0], ~m_ctrl[1], m_ctrl[2], m_ctrl[3], m_ctrl[6:4], m_err, m_latch};
    endfunction

    task automatic drive(bit req, bit we, logic [19:0] a, logic [7:0] d,
                         bit mv, logic [19:0] ma, bit pe);
        io_req = req; io_we = we; io_addr = a; io_wdata = d;
        mem_valid = mv; mem_addr = ma; mem_perr = pe;
    endtask

    task automatic idle();
        drive(0, 0, '0, '0, 0, '0, 0);
    endtask

    // one clock edge; model follows R2, R5, R6, R8, R9, R10
    task automatic tick();
        logic ld, clr, setc;
        @(posedge clk);
        ld   = io_req & io_we & io_addr[13];
        clr  = io_req & io_we & io_addr[14];
        setc = mem_valid & mem_perr & (mem_addr[19:12] == 8'd0) & ~m_ctrl[1];
        if (ld) begin
            m_err  = m_latch;
            m_ctrl = io_wdata[6:0];
        end
        if (setc) m_latch = 1'b1;
        else if (clr) m_latch = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_ctrl(logic [7:0] d);
        drive(1, 1, 20'h02000, d, 0, '0, 0); tick(); idle();
    endtask

    task automatic clear_latch();
        drive(1, 1, 20'h04000, 8'h5A, 0, '0, 0); tick(); idle();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] pages [4];
        pages[0] = 20'h00ABC; pages[1] = 20'h00FFF; pages[2] = 20'h01000; pages[3] = 20'h80000;

        idle();
        repeat (3) @(negedge clk);
        // R4: reset state
        chk("R4 reset", act_vec(), 16'b0000000_0_1_0_0_000_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 after release", act_vec(), exp_vec());

        // R1: selects for every combination of bits 11..14, req and we
        for (int a = 0; a < 16; a++) begin
            for (int r = 0; r < 2; r++) begin
                for (int w = 0; w < 2; w++) begin
                    drive(r[0], 1'b0, 20'(a) << 11, 8'h00, 0, '0, 0);
                    io_we = w[0];
                    io_we = 1'b0; // keep selects-only sweep free of side effects
                    #1;
                    chk("R1 pic_sel", {15'd0, pic_sel}, {15'd0, r[0] & a[0]});
                    chk("R1 dbg_sel", {15'd0, dbg_sel}, {15'd0, r[0] & a[1]});
                end
            end
        end
        // R1 with a write present: selects ignore io_we
        drive(1, 1, 20'h01800, 8'h00, 0, '0, 0); #1;
        chk("R1 selects during write", {14'd0, pic_sel, dbg_sel}, 16'd3);
        tick(); idle();
        chk("R1 write hit neither register nor latch", act_vec(), exp_vec());

        // R2/R3: every data value, then a read that must not load
        for (int d = 0; d < 256; d++) begin
            write_ctrl(8'(d));
            chk("R3 field map", act_vec(), exp_vec());
            drive(1, 0, 20'h02000, ~8'(d), 0, '0, 0); tick(); idle();
            chk("R2 read no load", act_vec(), exp_vec());
        end
        // R2: write without bit 13 does not load
        drive(1, 1, 20'hF9FFF, 8'h7F, 0, '0, 0); tick(); idle();
        chk("R2 write other bits no load", act_vec(), exp_vec());

        // R5/R6: every condition combination, checking on and off
        for (int en = 0; en < 2; en++) begin
            write_ctrl(en[0] ? 8'h01 : 8'h03);
            for (int p = 0; p < 4; p++) begin
                for (int v = 0; v < 2; v++) begin
                    for (int e = 0; e < 2; e++) begin
                        clear_latch();
                        drive(0, 0, '0, '0, v[0], pages[p], e[0]); tick(); idle();
                        chk((p < 2) ? "R5 set condition" : "R6 page decode", act_vec(), exp_vec());
                        tick();
                        chk("R7 sticky", act_vec(), exp_vec());
                    end
                end
            end
        end

        // R7/R8: latch set, read with bit 14 keeps it, write clears it
        write_ctrl(8'h01);
        drive(0, 0, '0, '0, 1, 20'h00010, 1); tick(); idle();
        chk("R7 irq raised", {15'd0, parity_irq}, 16'd1);
        drive(1, 0, 20'h04000, 8'hFF, 0, '0, 0); tick(); idle();
        chk("R8 read keeps latch", act_vec(), exp_vec());
        drive(1, 1, 20'h04000, 8'h00, 0, '0, 0); tick(); idle();
        chk("R8 write clears latch", {15'd0, parity_irq}, 16'd0);

        // R9: clear and error at one edge, from both starting states
        drive(1, 1, 20'h04000, 8'hA5, 1, 20'h00200, 1); tick(); idle();
        chk("R9 set wins from clear state", {15'd0, parity_irq}, 16'd1);
        drive(1, 1, 20'h04000, 8'h3C, 1, 20'h00200, 1); tick(); idle();
        chk("R9 set wins from set state", act_vec(), exp_vec());

        // R10: write captures pre-edge latch state
        write_ctrl(8'h11);
        chk("R10 captures set state", {15'd0, err_led}, 16'd1);
        clear_latch();
        chk("R10 holds between writes", {15'd0, err_led}, 16'd1);
        write_ctrl(8'h21);
        chk("R10 captures clear state", {15'd0, err_led}, 16'd0);

        // R11: combined load and clear
        drive(0, 0, '0, '0, 1, 20'h00001, 1); tick(); idle();
        drive(1, 1, 20'h06000, 8'h45, 0, '0, 0); tick(); idle();
        chk("R11 combined write", act_vec(), exp_vec());
        chk("R11 err_led pre-clear", {14'd0, err_led, parity_irq}, 16'b10);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule